// File: doc/BRIEF.md
# Three-Path Programmable Frequency Divider

This block divides a local-oscillator clock down to the rate used for phase comparison. One 16-bit divisor word serves three ways of dividing, chosen by two select inputs. The high-range path puts a divide-by-2 stage ahead of a swallow counter, so the total ratio is twice the programmed value. The low-range swallow path uses the same counter without the extra stage, so the programmed value is the ratio. The low-range direct path is a plain 12-bit counter. The swallow counter is built from two synchronous counters: an upper count of whole 32-cycle blocks (divisor / 32), then a tail of divisor mod 32 cycles.

Each path has a lowest legal divisor. A smaller value is raised to that minimum and a clamp flag is set. The divisor and the select inputs are sampled only when a division ends, so a period that is already running is never shortened. Each completed division gives one output pulse, exactly one input clock wide.

A state machine runs the sequence. ST_LOAD is the first cycle after reset; it samples the settings and moves to the start state of the chosen path. ST_MAIN counts 32-cycle blocks. At the end of the last block it goes to ST_SWAL if the swallow count is non-zero; if the count is zero, the division ends there. ST_SWAL counts the tail. ST_DIR runs the direct counter. When any counting state ends a division, it samples the settings again and goes to the start state of the new path: ST_MAIN for either swallow path, ST_DIR for the direct path. On the high-range path the counting states advance only on every second input cycle.

Top module: `fsyn_div`

## Requirements
- R1: While reset is asserted, div_pulse and div_clamped are 0. The first clock edge after reset samples the settings. The first div_pulse is high in the cycle after clock edge R+1 after reset, where R is the effective ratio.
- R2: With range_hi=1, div_pulse repeats every 2*N input cycles, where N is the effective divisor and the minimum N is 272.
- R3: With range_hi=0 and swallow_en=1, div_pulse repeats every N input cycles. This holds whether N mod 32 is zero or non-zero, and the minimum N is 272.
- R4: With range_hi=0 and swallow_en=0, div_pulse repeats every D input cycles, where D is div_word[11:0]. Bits 15:12 have no effect. The legal range is 4 to 4095.
- R5: A divisor below the minimum for the selected path (272 for the swallow paths, 4 for the direct path) is treated as that minimum.
- R6: div_clamped is 1 exactly when the divisor in use was clamped. It changes only at the first sampling after reset or in the cycle where div_pulse rises.
- R7: A change of div_word or of the select inputs during a division leaves the length of that division unchanged. The change takes effect from the next division.
- R8: div_pulse is high for exactly one input cycle per division.
- R9: swallow_en has no effect while range_hi=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_lo | input | 1 | Local-oscillator clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_word | input | 16 | Programmed divisor |
| range_hi | input | 1 | 1 selects the high-range path (divide-by-2 then swallow counter) |
| swallow_en | input | 1 | On the low range: 1 selects the swallow counter, 0 selects the direct divider |
| div_pulse | output | 1 | One-cycle pulse at the end of each division |
| div_clamped | output | 1 | Divisor in use was raised to the path minimum |

## Verification
Any wrong internal state shows up as a wrong spacing between output pulses; a single pulse interval is enough to see it. A block counter or swallow counter that is off by one moves the next pulse by 32 cycles or by 1 cycle. A divide-by-2 phase that is wrong makes the spacing on the high-range path odd. A setting sampled at the wrong time changes the period during which the inputs changed, or moves the change of the clamp flag away from the edge where the pulse rises. The bench measures every interval in input cycles and checks the clamp flag at the pulse where the settings took effect and in the cycles just before it.

// File: rtl/fsyn_div_pkg.sv
package fsyn_div_pkg;

    typedef enum logic [1:0] {
        PATH_HI,
        PATH_SWL,
        PATH_DIR
    } path_t;

    typedef enum logic [1:0] {
        ST_LOAD,
        ST_MAIN,
        ST_SWAL,
        ST_DIR
    } state_t;

endpackage

// File: rtl/fsyn_div_limit.sv
module fsyn_div_limit
    import fsyn_div_pkg::*;
#(
    parameter int DIV_W   = 16,
    parameter int DIR_W   = 12,
    parameter int SWL_MIN = 272,
    parameter int DIR_MIN = 4
) (
    input  logic [DIV_W-1:0] div_in,
    input  logic             sel_hi,
    input  logic             sel_swl,
    output path_t            path,
    output logic [DIV_W-1:0] eff_div,
    output logic             clamped
);
    logic [DIR_W-1:0] dir_part;

    assign dir_part = div_in[DIR_W-1:0];

    always_comb begin
        if (sel_hi || sel_swl) begin
            path    = sel_hi ? PATH_HI : PATH_SWL;
            clamped = (div_in < DIV_W'(SWL_MIN));
            eff_div = clamped ? DIV_W'(SWL_MIN) : div_in;
        end else begin
            path    = PATH_DIR;
            clamped = (dir_part < DIR_W'(DIR_MIN));
            eff_div = clamped ? DIV_W'(DIR_MIN) : DIV_W'(dir_part);
        end
    end

endmodule

// File: rtl/fsyn_div_pre2.sv
module fsyn_div_pre2 (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic bypass,
    output logic advance
);
    logic phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
        end else if (clear) begin
            phase_q <= 1'b0;
        end else if (run) begin
            phase_q <= ~phase_q;
        end
    end

    assign advance = bypass | phase_q;

endmodule

// File: rtl/fsyn_div.sv
module fsyn_div
    import fsyn_div_pkg::*;
#(
    parameter int DIV_W     = 16,
    parameter int DIR_W     = 12,
    parameter int BLK_SHIFT = 5,
    parameter int SWL_MIN   = 272,
    parameter int DIR_MIN   = 4
) (
    input  logic             clk_lo,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_word,
    input  logic             range_hi,
    input  logic             swallow_en,
    output logic             div_pulse,
    output logic             div_clamped
);
    localparam int BLK_W = DIV_W - BLK_SHIFT;
    localparam int SUB_W = BLK_SHIFT;

    state_t           state_q, state_d;
    path_t            path_q, new_path;
    logic [DIV_W-1:0] n_q, new_n;
    logic             new_clamp;
    logic             err_q;
    logic             pulse_q;
    logic [BLK_W-1:0] blk_q;
    logic [SUB_W-1:0] sub_q;
    logic [SUB_W-1:0] tail_q;
    logic [DIR_W-1:0] dcnt_q;
    logic [BLK_W-1:0] blk_total;
    logic [SUB_W-1:0] swallow;
    logic             adv;
    logic             term;
    logic             load;
    logic             counting;
    state_t           start_st;

    assign blk_total = n_q[DIV_W-1:BLK_SHIFT];
    assign swallow   = n_q[SUB_W-1:0];
    assign counting  = (state_q != ST_LOAD);
    assign load      = (state_q == ST_LOAD) || term;
    assign start_st  = (new_path == PATH_DIR) ? ST_DIR : ST_MAIN;

    fsyn_div_limit #(
        .DIV_W  (DIV_W),
        .DIR_W  (DIR_W),
        .SWL_MIN(SWL_MIN),
        .DIR_MIN(DIR_MIN)
    ) u_limit (
        .div_in (div_word),
        .sel_hi (range_hi),
        .sel_swl(swallow_en),
        .path   (new_path),
        .eff_div(new_n),
        .clamped(new_clamp)
    );

    fsyn_div_pre2 u_pre2 (
        .clk    (clk_lo),
        .rst_n  (rst_n),
        .clear  (load),
        .run    (counting),
        .bypass (path_q != PATH_HI),
        .advance(adv)
    );

    // next state and end-of-division detection
    always_comb begin
        state_d = state_q;
        term    = 1'b0;
        unique case (state_q)
            ST_LOAD: state_d = start_st;
            ST_MAIN: begin
                if (adv && (sub_q == '1) && (blk_q == blk_total - BLK_W'(1))) begin
                    if (swallow == '0) begin
                        term = 1'b1;
                    end else begin
                        state_d = ST_SWAL;
                    end
                end
            end
            ST_SWAL: begin
                if (adv && (tail_q == swallow - SUB_W'(1))) begin
                    term = 1'b1;
                end
            end
            ST_DIR: begin
                if (adv && (dcnt_q == n_q[DIR_W-1:0] - DIR_W'(1))) begin
                    term = 1'b1;
                end
            end
            default: state_d = ST_LOAD;
        endcase
        if (term) begin
            state_d = start_st;
        end
    end

    // state register
    always_ff @(posedge clk_lo or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOAD;
        end else begin
            state_q <= state_d;
        end
    end

    // settings and counters
    always_ff @(posedge clk_lo or negedge rst_n) begin
        if (!rst_n) begin
            path_q <= PATH_DIR;
            n_q    <= DIV_W'(DIR_MIN);
            blk_q  <= '0;
            sub_q  <= '0;
            tail_q <= '0;
            dcnt_q <= '0;
        end else if (load) begin
            path_q <= new_path;
            n_q    <= new_n;
            blk_q  <= '0;
            sub_q  <= '0;
            tail_q <= '0;
            dcnt_q <= '0;
        end else if (adv) begin
            unique case (state_q)
                ST_MAIN: begin
                    if (sub_q == '1) begin
                        blk_q <= blk_q + BLK_W'(1);
                    end
                    sub_q <= sub_q + SUB_W'(1);
                end
                ST_SWAL: tail_q <= tail_q + SUB_W'(1);
                ST_DIR:  dcnt_q <= dcnt_q + DIR_W'(1);
                default: ;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk_lo or negedge rst_n) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            pulse_q <= term;
            if (load) begin
                err_q <= new_clamp;
            end
        end
    end

    assign div_pulse   = pulse_q;
    assign div_clamped = err_q;

endmodule

// File: rtl/fsyn_div_chk.sv
module fsyn_div_chk (
    input logic clk,
    input logic rst_n,
    input logic pulse,
    input logic clamp,
    input logic loading,
    input logic hi_active
);
    logic [17:0] gap_q;
    logic        first_done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q        <= '0;
            first_done_q <= 1'b0;
        end else if (pulse) begin
            gap_q        <= '0;
            first_done_q <= 1'b1;
        end else if (gap_q != '1) begin
            gap_q <= gap_q + 18'd1;
        end
    end

    p_one_wide_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);

    p_clamp_at_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clamp) |-> (pulse || $past(loading)));

    p_min_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> (gap_q >= 18'd3));

    p_even_ratio_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && first_done_q && $past(hi_active)) |-> gap_q[0]);

endmodule

bind fsyn_div fsyn_div_chk u_chk (
    .clk      (clk_lo),
    .rst_n    (rst_n),
    .pulse    (div_pulse),
    .clamp    (div_clamped),
    .loading  (state_q == ST_LOAD),
    .hi_active(path_q == PATH_HI)
);

// File: tb/fsyn_div_tb.sv
`timescale 1ns/1ps
module fsyn_div_tb;
    logic        clk_lo = 1'b0;
    logic        rst_n  = 1'b0;
    logic [15:0] div_word = 16'd10;
    logic        range_hi = 1'b0;
    logic        swallow_en = 1'b0;
    logic        div_pulse;
    logic        div_clamped;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2.5 clk_lo = ~clk_lo;

    fsyn_div u_dut (
        .clk_lo     (clk_lo),
        .rst_n      (rst_n),
        .div_word   (div_word),
        .range_hi   (range_hi),
        .swallow_en (swallow_en),
        .div_pulse  (div_pulse),
        .div_clamped(div_clamped)
    );

    localparam int NV = 14;
    localparam int VH[NV]   = '{1, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    localparam int VS[NV]   = '{0, 1, 0, 1, 1, 1, 1, 0, 0, 0, 0, 0, 1, 0};
    localparam int VD[NV]   = '{272, 300, 100, 272, 289, 320, 5, 4, 100, 'h1005, 2, 0, 1000, 4095};
    localparam int VP[NV]   = '{544, 600, 544, 272, 289, 320, 272, 4, 100, 5, 4, 4, 1000, 4095};
    localparam int VE[NV]   = '{0, 0, 1, 0, 0, 0, 1, 0, 0, 0, 1, 1, 0, 0};
    localparam string VR[NV] = '{"R2", "R9", "R5", "R3", "R3", "R3", "R5",
                                 "R4", "R4", "R4", "R5", "R5", "R3", "R4"};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // counts negedges until div_pulse is seen high
    task automatic next_pulse(output int n);
        n = 0;
        do begin
            @(negedge clk_lo);
            n++;
        end while (!div_pulse && n < 150000);
    endtask

    task automatic set_mode(input int hi, input int sw, input int d);
        range_hi   = hi[0];
        swallow_en = sw[0];
        div_word   = d[15:0];
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk_lo) begin
        cycles++;
        if (cycles > 190000 && !done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 190000);
            finish_run();
        end
    end

    initial begin
        int n;
        int acc;
        bit early_ok;

        // R1: reset state and first pulse timing (direct path, ratio 10)
        set_mode(0, 0, 10);
        repeat (3) @(negedge clk_lo);
        check(div_pulse == 1'b0, "R1 pulse in reset", div_pulse, 0);
        check(div_clamped == 1'b0, "R1 clamp in reset", div_clamped, 0);
        rst_n = 1'b1;
        next_pulse(n);
        check(n == 11, "R1 first pulse", n, 11);

        // table walk
        for (int i = 0; i < NV; i++) begin
            set_mode(VH[i], VS[i], VD[i]);
            next_pulse(n);
            check(div_clamped == VE[i][0], {VR[i], " clamp flag"}, div_clamped, VE[i]);
            @(negedge clk_lo);
            check(div_pulse == 1'b0, "R8 width", div_pulse, 0);
            next_pulse(n);
            check(n + 1 == VP[i], {VR[i], " period"}, n + 1, VP[i]);
        end

        // R7: change mid-division does not shorten it
        set_mode(0, 0, 1000);
        next_pulse(n);
        next_pulse(n);
        acc = 0;
        repeat (300) begin
            @(negedge clk_lo);
            acc++;
        end
        set_mode(0, 0, 4);
        next_pulse(n);
        check(acc + n == 1000, "R7 running period kept", acc + n, 1000);
        next_pulse(n);
        check(n == 4, "R7 new period applied", n, 4);

        // R6: clamp flag stays old until the boundary pulse
        set_mode(0, 0, 2);
        early_ok = 1'b1;
        n = 0;
        do begin
            @(negedge clk_lo);
            n++;
            if (!div_pulse && div_clamped) early_ok = 1'b0;
        end while (!div_pulse && n < 100);
        check(early_ok, "R6 flag before boundary", div_clamped, 0);
        check(div_clamped == 1'b1, "R6 flag at boundary", div_clamped, 1);

        // R9: swallow_en toggled on high range, period stays 2N
        set_mode(1, 1, 280);
        next_pulse(n);
        swallow_en = 1'b0;
        next_pulse(n);
        check(n == 560, "R9 swallow_en ignored", n, 560);

        finish_run();
    end

endmodule